// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block lets a clocked host reach an external asynchronous static RAM of 8K bytes. The host raises a request with a direction flag, a 13-bit word address and, for stores, a byte of data. The controller then walks the memory through a fixed sequence of phases. First the address is presented on its own. Then the access window opens, during which both chip selects are asserted together with either the write strobe or the output enable. Finally a recovery phase lets the memory's outputs float, or completes the cycle time. A one-cycle completion pulse marks the end of each access.

Every phase length is derived at elaboration from nanosecond minimums and the clock period, with each result rounded up to whole cycles. At the default 4 ns clock, a store holds its write window for 20 cycles and then recovers for 4. A load holds its read window for 25 cycles and then waits 9 cycles for the bus to float. The write window also covers the rule that separates bus drivers when output enable could be low (35 ns plus 40 ns). The data driver toward the memory is switched on only while a store is in progress.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset the low-active select is high, the high-active select is low, the write strobe and output enable are both high (inactive), the data driver enable is low and `done` is low.
- R2: A request seen in the idle phase is accepted at that clock edge. For exactly one cycle afterwards, the new address is on `mem_addr` while every strobe is still inactive, so the address is set up before the selects move.
- R3: A store asserts `mem_cs_n`=0, `mem_cs`=1 and `mem_we_n`=0 together for exactly 20 consecutive cycles (defaults), with `mem_oe_n` held at 1.
- R4: During a store, `mem_dq_oe` is 1 from the first cycle of the write window through the single cycle after `mem_we_n` returns high, and 0 at all other times. While it is 1, `mem_dq_out` equals the stored byte.
- R5: A load asserts both selects and `mem_oe_n`=0 for exactly 25 cycles (defaults), with `mem_we_n` held at 1. `rdata` takes the value on `mem_dq_in` at the last cycle of that window.
- R6: After the window closes, all strobes stay inactive for 4 cycles after a store and for 9 cycles after a load before the access completes.
- R7: `done` is high for exactly one cycle: the first idle cycle after the recovery phase. `rdata` keeps its value until a later load completes.
- R8: A request, direction, address or data change seen while an access is in progress has no effect on that access.
- R9: `mem_addr` stays constant from acceptance until `done`, and it never changes while a select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled only when idle |
| we | input | 1 | 1 = store, 0 = load |
| addr | input | 13 | Word address |
| wdata | input | 8 | Byte to store |
| rdata | output | 8 | Byte captured by the last load |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 13 | Address to the memory |
| mem_cs_n | output | 1 | Low-active chip select |
| mem_cs | output | 1 | High-active chip select |
| mem_we_n | output | 1 | Low-active write strobe |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable of the data driver |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The bench runs stores and loads at the lowest and highest addresses and loads from locations that were never written. It also runs a load straight after a store to the same location and a store straight after a load. These show whether data reaches the right cell and whether the driver stays off until the bus has floated. In one access the request is held high while the address, data and direction are toggled, which separates a controller that re-samples its inputs mid-access from one that latches them. Every strobe is compared cycle by cycle against a phase-count model, so a window that is off by one cycle in either direction shows up.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  // Round a nanosecond minimum up to whole clock cycles.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  // A load of N makes the phase last exactly N cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (en) q <= din;
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 4,
  parameter int T_WP_NS   = 60,
  parameter int T_AW_NS   = 80,
  parameter int T_CW_NS   = 80,
  parameter int T_DW_NS   = 40,
  parameter int T_WHZ_NS  = 35,
  parameter int T_CYC_NS  = 100,
  parameter int T_AA_NS   = 100,
  parameter int T_OE_NS   = 50,
  parameter int T_HZ_NS   = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // Write window: pulse width, address-to-end, select-to-end and the
  // float-plus-setup rule that keeps two drivers off the bus.
  localparam int WR_CYC  = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                imax(ns2cyc(T_CW_NS, CLK_NS), ns2cyc(T_WHZ_NS + T_DW_NS, CLK_NS)));
  // Recovery pads the whole store (setup + window + recovery) to the cycle time.
  localparam int WR_HOLD = imax(1, ns2cyc(T_CYC_NS, CLK_NS) - 1 - WR_CYC);
  localparam int RD_CYC  = imax(imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)),
                                ns2cyc(T_CYC_NS, CLK_NS));
  localparam int RD_HOLD = imax(1, ns2cyc(T_HZ_NS, CLK_NS));
  localparam int MAX_CYC = imax(imax(WR_CYC, WR_HOLD), imax(RD_CYC, RD_HOLD));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_t            ph_q, ph_d;
  logic              op_we_q, op_we_d;
  logic              accept, cap_en, finish;
  logic              tmr_load, tmr_last;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic              cs_n_q, cs_q, we_n_q, oe_n_q, dq_oe_q, done_q;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk (clk),
    .rst (rst),
    .en  (cap_en),
    .din (mem_dq_in),
    .q   (rdata)
  );

  always_comb begin
    ph_d     = ph_q;
    op_we_d  = op_we_q;
    accept   = 1'b0;
    cap_en   = 1'b0;
    finish   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req) begin
          accept   = 1'b1;
          op_we_d  = we;
          ph_d     = PH_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(1);
        end
      end
      PH_SETUP: begin
        if (tmr_last) begin
          ph_d     = PH_ACTIVE;
          tmr_load = 1'b1;
          tmr_val  = op_we_q ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
        end
      end
      PH_ACTIVE: begin
        if (tmr_last) begin
          ph_d     = PH_HOLD;
          cap_en   = !op_we_q;
          tmr_load = 1'b1;
          tmr_val  = op_we_q ? CNT_W'(WR_HOLD) : CNT_W'(RD_HOLD);
        end
      end
      PH_HOLD: begin
        if (tmr_last) begin
          ph_d   = PH_IDLE;
          finish = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // Memory-side strobes are decoded from the next phase and registered,
  // so every pin changes on a clock edge together with the phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      op_we_q <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      cs_n_q  <= 1'b1;
      cs_q    <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      op_we_q <= op_we_d;
      if (accept) begin
        addr_q <= addr;
        wd_q   <= wdata;
      end
      cs_n_q  <= (ph_d != PH_ACTIVE);
      cs_q    <= (ph_d == PH_ACTIVE);
      we_n_q  <= !((ph_d == PH_ACTIVE) && op_we_d);
      oe_n_q  <= !((ph_d == PH_ACTIVE) && !op_we_d);
      dq_oe_q <= op_we_d && ((ph_d == PH_ACTIVE) ||
                             ((ph_q == PH_ACTIVE) && (ph_d == PH_HOLD)));
      done_q  <= finish;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wd_q;
  assign mem_cs_n   = cs_n_q;
  assign mem_cs     = cs_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_dq_oe  = dq_oe_q;
  assign done       = done_q;

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  // Both selects always agree on whether the part is chosen.
  assert_sel_pair_R3: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n == !mem_cs);

  // Output enable only while selected, and never together with the write strobe.
  assert_oe_selected_R5: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));

  // Driver on only in the write window or the cycle just after it.
  assert_drive_window_R4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

  // Address already settled in the cycle the selects assert.
  assert_addr_setup_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cs_n) |-> $stable(mem_addr));

  // Address frozen while the part stays selected.
  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // Completion is a single-cycle pulse.
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_cs    (mem_cs),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_port_ctrl.sv
`timescale 1ns/1ps
module test_sram_port_ctrl;

  localparam int WR_ACT  = 20;
  localparam int WR_HOLD = 4;
  localparam int RD_ACT  = 25;
  localparam int RD_HOLD = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        done;
  logic [12:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int unsigned checks = 0;
  int unsigned errors = 0;

  logic [7:0] mem_model [0:8191];
  logic [7:0] ref_mem   [0:8191];

  always #2 clk = ~clk;

  sram_port_ctrl i_sram_port_ctrl (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Behavioural memory: drives data only when selected and reading,
  // stores on the closing edge of the write overlap.
  assign mem_dq_in = (!mem_cs_n && mem_cs && mem_we_n && !mem_oe_n) ?
                     mem_model[mem_addr] : 8'hA5;

  bit          prev_wr = 1'b0;
  logic [12:0] prev_a;
  logic [7:0]  prev_d;
  always @(negedge clk) begin
    bit wr_now;
    wr_now = !mem_cs_n && mem_cs && !mem_we_n;
    if (prev_wr && !wr_now) mem_model[prev_a] = prev_d;
    prev_wr = wr_now;
    prev_a  = mem_addr;
    prev_d  = mem_dq_oe ? mem_dq_out : 8'h00;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access, compared every cycle against the phase-count model.
  // With hog set, req stays high and the inputs wander during the access (R8).
  task automatic access(input bit w, input logic [12:0] a, input logic [7:0] d,
                        input bit hog);
    int act_n, dn;
    act_n = w ? WR_ACT : RD_ACT;
    dn    = act_n + (w ? WR_HOLD : RD_HOLD) + 2;
    req = 1'b1; we = w; addr = a; wdata = d;
    for (int t = 1; t <= dn; t++) begin
      bit in_act;
      @(negedge clk);
      if (hog && t < dn) begin
        req = 1'b1; we = !w; addr = ~a; wdata = ~d;
      end else begin
        req = 1'b0;
      end
      in_act = (t >= 2) && (t <= act_n + 1);
      chk(hog ? "R8 address kept" : "R9 address", 16'(mem_addr), 16'(a));
      if (t == 1) chk("R2 setup cycle strobes", {12'h0, mem_cs_n, mem_cs, mem_we_n, mem_oe_n},
                      16'b1011);
      chk(w ? "R3 selects" : "R5 selects", {14'h0, mem_cs_n, mem_cs},
          {14'h0, !in_act, in_act});
      chk(w ? "R3 write strobe" : "R5 write strobe", 16'(mem_we_n), 16'(!(w && in_act)));
      chk(w ? "R3 output enable" : "R5 output enable", 16'(mem_oe_n), 16'(!(!w && in_act)));
      chk("R4 driver enable", 16'(mem_dq_oe), 16'(w && t >= 2 && t <= act_n + 2));
      if (mem_dq_oe) chk("R4 driven data", 16'(mem_dq_out), 16'(d));
      chk(t == dn ? "R7 done pulse" : "R6 recovery before done", 16'(done), 16'(t == dn));
    end
    if (w) ref_mem[a] = d;
    else   chk("R5 read data", 16'(rdata), 16'(ref_mem[a]));
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) begin
      mem_model[i] = 8'(i) ^ 8'(i >> 8) ^ 8'h3C;
      ref_mem[i]   = 8'(i) ^ 8'(i >> 8) ^ 8'h3C;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset strobes", {11'h0, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe},
        16'b10110);
    chk("R1 reset done", 16'(done), 16'h0);

    access(1'b1, 13'h0000, 8'h5A, 1'b0);
    access(1'b1, 13'h1FFF, 8'hC3, 1'b0);
    access(1'b0, 13'h1FFF, 8'h00, 1'b0);
    access(1'b0, 13'h0000, 8'h00, 1'b0);
    access(1'b0, 13'h0123, 8'h00, 1'b0);
    // rdata must survive a following store (R7)
    access(1'b1, 13'h0ABC, 8'h96, 1'b0);
    chk("R7 rdata held", 16'(rdata), 16'(ref_mem[13'h0123]));
    access(1'b0, 13'h0ABC, 8'h00, 1'b0);
    access(1'b1, 13'h0ABC, 8'h69, 1'b0);
    access(1'b0, 13'h0ABC, 8'h00, 1'b0);
    // inputs wander during the access; the decoy ~addr must stay untouched
    access(1'b1, 13'h0F0F, 8'h3E, 1'b1);
    access(1'b0, 13'h0F0F, 8'h00, 1'b0);
    access(1'b0, 13'h10F0, 8'h00, 1'b0);
    access(1'b0, 13'h1555, 8'h00, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule